// File: doc/BRIEF.md
# ATM Cell Payload Self-Synchronizing Scrambler

This block scrambles or descrambles the payload of ATM cells that arrive as a byte stream. A start-of-cell flag marks the first byte of each 53-byte cell. That byte and the four bytes after it form the cell header and pass through unchanged. Every other byte is combined with a self-synchronizing x^43+1 sequence, eight bits per clock.

In scramble mode, each output bit is the input bit XOR the scrambled bit that left the block 43 bit-times earlier. In descramble mode, each output bit is the received bit XOR the received bit 43 bit-times earlier. The descrambler therefore needs no alignment with the far end: after 43 payload bits its output equals the original data, whatever its starting state was.

Both sides of the block use valid/ready streams. A byte moves when valid and ready are both high at a rising clock edge. The upstream side may hold its byte for as long as it likes. The downstream side may deassert `out_ready` at any time. A single register slice sits between input and output, and `in_ready` is high exactly when that slice is empty or is being emptied in the same cycle. The block therefore runs at one byte per clock without bubbles. It never drops or repeats a byte.

Top module: `atm_payload_scrambler`

## Requirements
- R1: After reset, `out_valid` is low and the 43-bit history holds all ones. In scramble mode, a first payload byte of 0x00 therefore leaves as 0xFF.
- R2: In scramble mode (`descramble` = 0), each payload bit is XORed with the output bit 43 positions earlier. Bits enter in time order MSB first (bit 7 is the first bit of a byte). All eight bits of a byte are processed in one clock.
- R3: A byte accepted with `in_sop` high, and the four bytes accepted after it, leave the block bit-for-bit unchanged. `out_sop` follows the byte that carried `in_sop`.
- R4: The history does not advance during header bytes. The first payload byte after a header continues from the state left by the last payload byte before that header.
- R5: In descramble mode (`descramble` = 1), each payload bit is XORed with the received bit 43 positions earlier, and the history shifts in the received bits. A stream scrambled from an all-ones history and descrambled from reset is recovered exactly.
- R6: In descramble mode, starting from any history state, every payload bit from the 44th payload bit onward equals the original unscrambled bit. This covers the 7th payload byte and later.
- R7: Bytes accepted after reset and before the first `in_sop` are treated as payload.
- R8: `in_ready` is high exactly when the output slice is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_sop` stay unchanged.
- R9: A byte accepted in one cycle is presented with `out_valid` high in the next cycle. Bytes leave in the order they were accepted, none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| descramble | input | 1 | 0 = scramble, 1 = descramble; sampled with each accepted byte |
| in_data | input | 8 | Incoming byte, MSB transmitted first |
| in_sop | input | 1 | Marks the first byte of a cell |
| in_valid | input | 1 | Incoming byte is present |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_data | output | 8 | Outgoing byte |
| out_sop | output | 1 | Outgoing byte is the first of a cell |
| out_valid | output | 1 | Outgoing byte is present |
| out_ready | input | 1 | Downstream takes the byte this cycle |

## Verification
The bench targets the header window. If that window were one byte short or long, a header byte would be scrambled or a payload byte would be copied. If the history kept shifting through headers, every payload after the first cell would diverge. The reset state is tested through a zero payload that must come out as all ones. Bit order is tested with asymmetric patterns that a reversed tap would corrupt. Two descramble cases close the loop: one recovers a stream from a matching start, and one recovers a stream from a mismatched start after six payload bytes, which exposes taps fed from the output instead of the input. Random back-pressure on the output exposes a slice that overwrites or repeats a held byte.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned POLY_LAG  = 43;
  localparam int unsigned HDR_BYTES = 5;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sop;
  } scr_beat_t;
endpackage

// File: rtl/scr_cell_phase.sv
module scr_cell_phase #(
  parameter int unsigned HDR_BYTES = 5,
  localparam int unsigned CW = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sop,
  input  logic take,
  output logic in_header
);
  logic [CW-1:0] hdr_left;

  assign in_header = sop || (hdr_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_left <= '0;
    end else if (take) begin
      if (sop)                 hdr_left <= CW'(HDR_BYTES - 1);
      else if (hdr_left != '0) hdr_left <= hdr_left - 1'b1;
    end
  end
endmodule

// File: rtl/scr_core.sv
module scr_core #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAG = 43
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         descramble,
  input  logic         bypass,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // hist[0] is the newest bit; hist[LAG-1] the oldest
  logic [LAG-1:0] hist;
  logic [W-1:0]   mixed;
  logic [W-1:0]   feed;

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      assign mixed[g] = din[g] ^ hist[LAG-W+g];
      assign feed[g]  = descramble ? din[g] : mixed[g];
    end
  endgenerate

  assign dout = bypass ? din : mixed;

  always_ff @(posedge clk) begin
    if (!rst_n)              hist <= '1;
    else if (take && !bypass) hist <= {hist[LAG-W-1:0], feed};
  end
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_data,
  input  logic         d_sop,
  input  logic         d_valid,
  output logic         d_ready,
  output logic [W-1:0] q_data,
  output logic         q_sop,
  output logic         q_valid,
  input  logic         q_ready
);
  assign d_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_sop   <= 1'b0;
    end else if (d_ready) begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_data <= d_data;
        q_sop  <= d_sop;
      end
    end
  end
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned DW   = BYTE_W,
  parameter int unsigned LAG  = POLY_LAG,
  parameter int unsigned HDRN = HDR_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          descramble,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_valid,
  input  logic          out_ready
);
  logic          take;
  logic          hdr_now;
  logic [DW-1:0] core_out;

  assign take = in_valid && in_ready;

  scr_cell_phase #(.HDR_BYTES(HDRN)) u_phase (
    .clk(clk), .rst_n(rst_n), .sop(in_sop), .take(take), .in_header(hdr_now)
  );

  scr_core #(.W(DW), .LAG(LAG)) u_core (
    .clk(clk), .rst_n(rst_n), .descramble(descramble), .bypass(hdr_now),
    .take(take), .din(in_data), .dout(core_out)
  );

  scr_out_stage #(.W(DW)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .d_data(core_out), .d_sop(in_sop), .d_valid(in_valid), .d_ready(in_ready),
    .q_data(out_data), .q_sop(out_sop), .q_valid(out_valid), .q_ready(out_ready)
  );
endmodule

// File: rtl/atm_payload_scrambler_chk.sv
module atm_payload_scrambler_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] in_data,
  input logic          in_sop,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sop,
  input logic          out_valid,
  input logic          out_ready
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_SOP_BYTE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop) |=> (out_sop && out_data == $past(in_data))); // R3

  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

bind atm_payload_scrambler atm_payload_scrambler_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sop(in_sop),
  .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
  .out_sop(out_sop), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_atm_payload_scrambler.sv
module sim_atm_payload_scrambler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       descramble = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_sop;
  logic       out_valid;
  logic       out_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit bp_on = 1'b0;
  bit done  = 1'b0;

  logic [7:0] q_data[$];
  logic       q_sop[$];
  string      q_tag[$];

  logic [42:0] mh;      // bench model of the design history
  int          mcnt;    // header bytes remaining in bench model

  always #4 clk = ~clk; // 125 MHz

  atm_payload_scrambler u0 (
    .clk(clk), .rst_n(rst_n), .descramble(descramble),
    .in_data(in_data), .in_sop(in_sop), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_sop(out_sop), .out_valid(out_valid), .out_ready(out_ready)
  );

  // Serial, bit at a time: oldest bit sits at [42], newest enters at [0]
  function automatic logic [7:0] ref_byte(input logic [7:0] d, input bit descr,
                                          inout logic [42:0] h);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) begin
      logic b;
      b = d[7-j] ^ h[42];
      r[7-j] = b;
      h = {h[41:0], descr ? d[7-j] : b};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] d, input bit s);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s;
    #2;
    while (!in_ready) begin
      @(negedge clk); #2;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  // use_exp forces the expected value instead of the model result
  task automatic xfer(input logic [7:0] d, input bit s, input string tag,
                      input bit use_exp = 1'b0, input logic [7:0] forced = '0);
    bit hdr;
    logic [7:0] e;
    hdr = s || (mcnt != 0);
    if (s) mcnt = 4; else if (mcnt != 0) mcnt--;
    e = hdr ? d : ref_byte(d, descramble, mh);
    if (use_exp) e = forced;
    q_data.push_back(e); q_sop.push_back(s); q_tag.push_back(tag);
    drive(d, s);
  endtask

  task automatic do_reset();
    in_valid = 1'b0; in_sop = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mh = '1; mcnt = 0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (q_data.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check(q_data.size() == 0, "R9 drain", 9'(q_data.size()), 9'd0);
  endtask

  // Monitor: sample mid-cycle, after out_ready has settled
  logic [8:0] prev_beat;
  bit         prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst_n) begin
        prev_stall = 1'b0;
      end else begin
        if (prev_stall)
          check({out_data, out_sop} == prev_beat && out_valid, "R8 held while stalled",
                {out_data, out_sop}, prev_beat);
        prev_stall = out_valid && !out_ready;
        prev_beat  = {out_data, out_sop};
        if (out_valid && out_ready) begin
          if (q_data.size() == 0) begin
            check(1'b0, "R9 unexpected output", {out_data, out_sop}, 9'h000);
          end else begin
            logic [7:0] ed; logic es; string et;
            ed = q_data.pop_front(); es = q_sop.pop_front(); et = q_tag.pop_front();
            check(out_data == ed && out_sop == es, et, {out_data, out_sop}, {ed, es});
          end
        end
      end
    end
  end

  // Back-pressure generator
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [42:0] aux;
    do_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid low after reset", {8'h00, out_valid}, 9'h000);

    // R7: payload before any start-of-cell; R1: zero in gives FF out
    xfer(8'h00, 1'b0, "R1 R7 first payload byte", 1'b1, 8'hFF);
    xfer(8'h00, 1'b0, "R7 pre-cell payload");
    idle(); drain();

    // R2 R3 R4: cells of asymmetric patterns, scramble mode
    for (int c = 0; c < 4; c++) begin
      xfer(8'hA0 + 8'(c), 1'b1, "R3 header byte");
      for (int k = 1; k < 5; k++) xfer(8'(c * 16 + k), 1'b0, "R3 header byte");
      for (int k = 0; k < 48; k++)
        xfer((c[0] ? 8'h01 : 8'h80) ^ 8'(k * 7), 1'b0, "R2 R4 payload byte");
    end
    idle(); drain();

    // R8 R9: random data under back-pressure with idle gaps
    bp_on = 1'b1;
    for (int c = 0; c < 6; c++) begin
      for (int k = 0; k < 53; k++) begin
        xfer(8'($urandom), k == 0, k < 5 ? "R3 R8 header under stall" : "R8 R9 payload under stall");
        if ($urandom_range(0, 5) == 0) idle();
      end
    end
    idle(); drain();
    bp_on = 1'b0;

    // R5: round trip from matching all-ones start
    do_reset();
    descramble = 1'b1;
    aux = '1;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 53; k++) begin
        logic [7:0] p, s;
        p = 8'($urandom);
        s = (k < 5) ? p : ref_byte(p, 1'b0, aux);
        xfer(s, k == 0, "R5 recovered byte", 1'b1, p);
      end
    end
    idle(); drain();

    // R6: far end starts from a different state
    do_reset();
    descramble = 1'b1;
    aux = 43'h2A5_5A5A_1234;
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 53; k++) begin
        logic [7:0] p, s;
        p = 8'($urandom);
        s = (k < 5) ? p : ref_byte(p, 1'b0, aux);
        if (c == 0 && k >= 5 && k < 11) xfer(s, k == 0, "R6 early descrambled byte");
        else xfer(s, k == 0, "R6 resynchronized byte", 1'b1, p);
      end
    end
    idle(); drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule